// File: doc/BRIEF.md
# Asynchronous Bus Glue Logic

This block sits between a 16-bit asynchronous bus master and a mix of 8-bit and 16-bit peripherals. It takes the master's address strobe, the two byte-lane data strobes, the read/write line, the three function-code bits and the top address bits. From these it forms read and write enables that always have a valid level, per-byte write enables for 8-bit parts, an interrupt-acknowledge flag, a bank of eight main chip selects, and a second bank of 8 or 16 I/O chip selects. The second bank sits under one main-bank slot.

It also returns the transfer-acknowledge handshake to the master. The handshake comes from a wait-state counter whose length is set on an input. The output is an open-drain enable: it either pulls the shared line low or releases it, and never drives it high. The address bus has no bit 0, so the byte lane is chosen only by the two data strobes. The upper strobe selects the even byte and the lower strobe selects the odd byte. Every strobe is active low. The read/write line reads high for a read and low for a write.

Top module: `busglue_top`

## Requirements
- R1: `rd_n` is low exactly when the reset is released, `as_n` is low and `rw` is 1. `wr_n` is low exactly when the reset is released, `as_n` is low and `rw` is 0. Both are high whenever `as_n` is high, so the two never float and are never low together.
- R2: `wr_uds_n` is low exactly when the reset is released, `as_n` is low, `rw` is 0 and `uds_n` is low.
- R3: `wr_lds_n` is low exactly when the reset is released, `as_n` is low, `rw` is 0 and `lds_n` is low.
- R4: `iack_n` is low exactly when `fc` equals 3'b111, and high for every other function-code value.
- R5: With the reset released, `as_n` low and `fc` not 3'b111, exactly one bit of `cs_main_n` is low. That bit's index is the top three address bits, `addr_hi[ADDR_MSB:ADDR_MSB-2]`.
- R6: Bit k of `cs_io_n` is low only while main select number IO_BANK (default 7) is low and the I/O index field equals k. The I/O index field is the log2(IO_COUNT) address bits directly below the main field: bits 20:18 for 8 selects and bits 20:17 for 16 selects.
- R7: Every bit of `cs_main_n` and `cs_io_n` is high while `as_n` is high or during an interrupt-acknowledge cycle (`fc` = 3'b111).
- R8: After `as_n` goes low, `dtack_oe` rises after exactly `wait_cycles`+1 rising clock edges with `as_n` low. It then stays high while `as_n` stays low. If `as_n` is negated before `dtack_oe` rises, the count starts again from zero.
- R9: `dtack_oe` falls in the same cycle that `as_n` goes high, with no clock edge needed. It is never high while `as_n` is high.
- R10: While `rst_n` is low, every chip select, `rd_n`, `wr_n` and both byte write enables are high, and `dtack_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the acknowledge timer |
| rst_n | input | 1 | Active-low reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper (even) byte strobe, active low |
| lds_n | input | 1 | Lower (odd) byte strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| fc | input | 3 | Bus-cycle function code |
| addr_hi | input | ADDR_MSB-IO_LSB+1 | Top address bits, ADDR_MSB down to IO_LSB |
| wait_cycles | input | WS_W | Wait states inserted before the acknowledge |
| rd_n | output | 1 | Read enable, always driven |
| wr_n | output | 1 | Write enable, always driven |
| wr_uds_n | output | 1 | Even-byte write enable |
| wr_lds_n | output | 1 | Odd-byte write enable |
| iack_n | output | 1 | Interrupt-acknowledge cycle flag |
| cs_main_n | output | 8 | Main chip selects, active low |
| cs_io_n | output | IO_COUNT | I/O chip selects, active low |
| dtack_oe | output | 1 | 1 = pull the acknowledge line low, 0 = release it |

## Verification
Some properties are checked by assertions on every cycle. At most one main select is ever low. An I/O select is never low unless its parent main select is low. All selects are quiet while the address strobe is high. Read and write are never low together. The acknowledge is never pulled while the strobe is high, and once pulled it holds while the strobe stays low. Other behaviour can only be shown by the bench scenarios. These cover the exact mapping of address fields onto select numbers, the byte-lane and interrupt-acknowledge decode across every strobe, direction and function-code combination, the exact wait-state count, restarting the count after an early strobe release, and the outputs held while in reset.

// File: rtl/busglue_pkg.sv
package busglue_pkg;

    // Function-code value that marks an interrupt-acknowledge bus cycle
    localparam logic [2:0] FC_INT_ACK = 3'b111;

    // Size of the main select bank and of its address field
    localparam int MAIN_COUNT = 8;
    localparam int MAIN_W     = 3;

    typedef enum logic {
        ACK_COUNTING = 1'b0,
        ACK_HOLDING  = 1'b1
    } ack_phase_e;

endpackage

// File: rtl/bg_strobe_decode.sv
module bg_strobe_decode
    import busglue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       uds_n,
    input  logic       lds_n,
    input  logic       rw,
    input  logic [2:0] fc,
    output logic       rd_n,
    output logic       wr_n,
    output logic       wr_uds_n,
    output logic       wr_lds_n,
    output logic       iack_n
);

    logic cycle_live;
    logic is_write;

    always_comb begin
        // The strobe qualifies the direction line, so both outputs have
        // a defined level even when the master releases rw.
        cycle_live = rst_n & ~as_n;
        is_write   = cycle_live & ~rw;
        rd_n       = ~(cycle_live & rw);
        wr_n       = ~is_write;
        wr_uds_n   = ~(is_write & ~uds_n);
        wr_lds_n   = ~(is_write & ~lds_n);
        iack_n     = ~(fc == FC_INT_ACK);
    end

    // R1: read and write enables are never low together
    a_r1_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2: even-byte write enable only inside a write cycle
    a_r2_uds_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_uds_n |-> !wr_n);

    // R3: odd-byte write enable only inside a write cycle
    a_r3_lds_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lds_n |-> !wr_n);

endmodule

// File: rtl/bg_select_decode.sv
module bg_select_decode
    import busglue_pkg::*;
#(
    parameter int ADDR_MSB = 23,
    parameter int IO_COUNT = 8,
    parameter int IO_BANK  = 7,
    localparam int IO_W    = $clog2(IO_COUNT),
    localparam int MAIN_LSB = ADDR_MSB - MAIN_W + 1,
    localparam int IO_LSB  = MAIN_LSB - IO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     as_n,
    input  logic                     int_ack,
    input  logic [ADDR_MSB:IO_LSB]   addr_hi,
    output logic [MAIN_COUNT-1:0]    cs_main_n,
    output logic [IO_COUNT-1:0]      cs_io_n
);

    logic [MAIN_W-1:0] main_idx;
    logic [IO_W-1:0]   io_idx;
    logic              main_en;
    logic              io_en;

    always_comb begin
        main_idx = addr_hi[ADDR_MSB:MAIN_LSB];
        io_idx   = addr_hi[MAIN_LSB-1:IO_LSB];
        main_en  = rst_n & ~as_n & ~int_ack;
        io_en    = main_en & (main_idx == MAIN_W'(IO_BANK));
    end

    for (genvar g = 0; g < MAIN_COUNT; g++) begin : g_main
        assign cs_main_n[g] = ~(main_en && (main_idx == MAIN_W'(g)));
    end

    for (genvar g = 0; g < IO_COUNT; g++) begin : g_io
        assign cs_io_n[g] = ~(io_en && (io_idx == IO_W'(g)));
    end

    // R5: at most one main select active
    a_r5_main_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_main_n) <= 1);

    // R6: an I/O select needs its parent main select
    a_r6_io_needs_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (~&cs_io_n) |-> !cs_main_n[IO_BANK]);

    // R7: all selects quiet with the strobe idle or during interrupt acknowledge
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n || int_ack) |-> ((&cs_main_n) && (&cs_io_n)));

endmodule

// File: rtl/bg_ack_timer.sv
module bg_ack_timer
    import busglue_pkg::*;
#(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            as_n,
    input  logic [WS_W-1:0] wait_cycles,
    output logic            dtack_oe
);

    typedef struct packed {
        logic [WS_W-1:0] cnt;
        ack_phase_e      phase;
    } timer_t;

    timer_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (as_n) begin
            st_d.cnt   = '0;
            st_d.phase = ACK_COUNTING;
        end else if (st_q.phase == ACK_COUNTING) begin
            if (st_q.cnt == wait_cycles) begin
                st_d.phase = ACK_HOLDING;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, phase: ACK_COUNTING};
        end else begin
            st_q <= st_d;
        end
    end

    // The strobe gates the registered phase, so the release needs no edge.
    assign dtack_oe = rst_n & ~as_n & (st_q.phase == ACK_HOLDING);

    // R9: never pull the acknowledge while the strobe is idle
    a_r9_ack_needs_as: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_oe |-> !as_n);

    // R8: once pulled, the acknowledge holds while the strobe stays low
    a_r8_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_oe |=> (as_n || dtack_oe));

endmodule

// File: rtl/busglue_top.sv
module busglue_top
    import busglue_pkg::*;
#(
    parameter int ADDR_MSB = 23,
    parameter int IO_COUNT = 8,
    parameter int IO_BANK  = 7,
    parameter int WS_W     = 4,
    localparam int IO_LSB  = ADDR_MSB - MAIN_W + 1 - $clog2(IO_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   as_n,
    input  logic                   uds_n,
    input  logic                   lds_n,
    input  logic                   rw,
    input  logic [2:0]             fc,
    input  logic [ADDR_MSB:IO_LSB] addr_hi,
    input  logic [WS_W-1:0]        wait_cycles,
    output logic                   rd_n,
    output logic                   wr_n,
    output logic                   wr_uds_n,
    output logic                   wr_lds_n,
    output logic                   iack_n,
    output logic [MAIN_COUNT-1:0]  cs_main_n,
    output logic [IO_COUNT-1:0]    cs_io_n,
    output logic                   dtack_oe
);

    bg_strobe_decode i_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .uds_n    (uds_n),
        .lds_n    (lds_n),
        .rw       (rw),
        .fc       (fc),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wr_uds_n (wr_uds_n),
        .wr_lds_n (wr_lds_n),
        .iack_n   (iack_n)
    );

    bg_select_decode #(
        .ADDR_MSB (ADDR_MSB),
        .IO_COUNT (IO_COUNT),
        .IO_BANK  (IO_BANK)
    ) i_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .int_ack   (~iack_n),
        .addr_hi   (addr_hi),
        .cs_main_n (cs_main_n),
        .cs_io_n   (cs_io_n)
    );

    bg_ack_timer #(
        .WS_W (WS_W)
    ) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .as_n        (as_n),
        .wait_cycles (wait_cycles),
        .dtack_oe    (dtack_oe)
    );

    // R10: everything inactive while in reset
    always_comb begin
        if (rst_n == 1'b0) begin
            a_r10_reset_quiet: assert ((&cs_main_n) && (&cs_io_n) && rd_n && wr_n
                                       && wr_uds_n && wr_lds_n && !dtack_oe);
        end
    end

endmodule

// File: tb/test_busglue_top.sv
module test_busglue_top;

    localparam int CLK_PERIOD = 10;
    localparam int IO_COUNT   = 16;
    localparam int WS_W       = 4;
    localparam int ADDR_MSB   = 23;
    localparam int IO_LSB     = 17;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   as_n, uds_n, lds_n, rw;
    logic [2:0]             fc;
    logic [ADDR_MSB:IO_LSB] addr_hi;
    logic [WS_W-1:0]        wait_cycles;
    logic                   rd_n, wr_n, wr_uds_n, wr_lds_n, iack_n, dtack_oe;
    logic [7:0]             cs_main_n;
    logic [IO_COUNT-1:0]    cs_io_n;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busglue_top #(
        .ADDR_MSB (ADDR_MSB),
        .IO_COUNT (IO_COUNT),
        .IO_BANK  (7),
        .WS_W     (WS_W)
    ) i_busglue_top (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rw(rw), .fc(fc), .addr_hi(addr_hi), .wait_cycles(wait_cycles),
        .rd_n(rd_n), .wr_n(wr_n), .wr_uds_n(wr_uds_n), .wr_lds_n(wr_lds_n),
        .iack_n(iack_n), .cs_main_n(cs_main_n), .cs_io_n(cs_io_n),
        .dtack_oe(dtack_oe)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One ack scenario: strobe low at a falling edge, count falling edges
    task automatic ack_run(input int w);
        int first = -1;
        wait_cycles = WS_W'(w);
        @(negedge clk);
        as_n = 1'b0;
        for (int k = 1; k <= w + 2; k++) begin
            @(negedge clk);
            if (dtack_oe === 1'b1 && first < 0) first = k;
        end
        check("R8 wait-state count", 64'(first), 64'(w + 1));
        check("R8 ack held", {63'd0, dtack_oe}, 64'd1);
        as_n = 1'b1;
        #1;
        check("R9 release without edge", {63'd0, dtack_oe}, 64'd0);
        @(negedge clk);
        check("R9 stays released", {63'd0, dtack_oe}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0; rw = 1'b0;
        fc = 3'b001; addr_hi = '0; wait_cycles = '0;

        // R10: reset holds everything inactive with a live write strobe
        repeat (3) @(negedge clk);
        check("R10 main selects", 64'(cs_main_n), 64'hFF);
        check("R10 io selects", 64'(cs_io_n), 64'hFFFF);
        check("R10 rd/wr", {62'd0, rd_n, wr_n}, 64'd3);
        check("R10 byte writes", {62'd0, wr_uds_n, wr_lds_n}, 64'd3);
        check("R10 ack released", {63'd0, dtack_oe}, 64'd0);
        as_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R7: exhaustive sweep of strobes, direction, function code, address
        for (int c = 0; c < 128; c++) begin
            for (int a = 0; a < 128; a++) begin
                logic act, iack, en;
                logic [7:0]  e_main;
                logic [15:0] e_io;
                int mi, ii;
                as_n = c[0]; uds_n = c[1]; lds_n = c[2]; rw = c[3];
                fc = 3'(c >> 4);
                addr_hi = 7'(a);
                mi = a >> 4;
                ii = a & 15;
                #1;
                act  = !as_n;
                iack = (fc == 3'b111);
                en   = act && !iack;
                e_main = en ? ~(8'd1 << mi) : 8'hFF;
                e_io   = (en && mi == 7) ? ~(16'd1 << ii) : 16'hFFFF;
                check("R1 rd_n", {63'd0, rd_n}, {63'd0, !(act && rw)});
                check("R1 wr_n", {63'd0, wr_n}, {63'd0, !(act && !rw)});
                check("R2 wr_uds_n", {63'd0, wr_uds_n}, {63'd0, !(act && !rw && !uds_n)});
                check("R3 wr_lds_n", {63'd0, wr_lds_n}, {63'd0, !(act && !rw && !lds_n)});
                check("R4 iack_n", {63'd0, iack_n}, {63'd0, !iack});
                check("R5 R7 main selects", 64'(cs_main_n), 64'(e_main));
                check("R6 R7 io selects", 64'(cs_io_n), 64'(e_io));
            end
        end
        as_n = 1'b1; fc = 3'b101; rw = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // R8/R9: several wait-state settings including the largest
        ack_run(0);
        ack_run(1);
        ack_run(2);
        ack_run(5);
        ack_run(15);

        // R8: early release restarts the count
        wait_cycles = 4'd5;
        @(negedge clk);
        as_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 no early ack", {63'd0, dtack_oe}, 64'd0);
        as_n = 1'b1;
        @(negedge clk);
        ack_run(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule